// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit data path of a small load/store processor that spreads each instruction across several clock cycles. One memory port carries both instruction fetches and data accesses, and a single ALU is reused for the PC increment, the branch target, the effective address and the arithmetic itself. Values that must survive from one step to the next are held in internal registers: the instruction register, the memory data register, the two operand registers and the ALU result register.

The block holds no sequencing logic of its own. A separate controller drives every multiplexer select and every write enable through the `ctl_*` inputs, one set per cycle. It reads back the opcode, the function field and the ALU zero flag to choose its next step. Memory sits outside the block and answers combinationally on `mem_rdata` for the address presented on `mem_addr`.

Top module: `mc_datapath`

## Requirements
- R1: After synchronous reset the PC holds `RESET_PC` (default 0) and the instruction register holds 0. With `ctl_addr_sel`=0 the PC appears on `mem_addr`.
- R2: When `ctl_ir_wr` is 1, the instruction register loads `mem_rdata` at the clock edge. Otherwise it holds its value. With the ALU set to PC+4 (`ctl_alu_a_sel`=0, `ctl_alu_b_sel`=1, add) and `ctl_pc_wr`=1, `ctl_pc_src`=0, the PC steps by 4.
- R3: The operand registers A and B load, one edge later, the registers named by instruction bits 25:21 and 20:16. `ir_opcode` shows bits 31:26 and `ir_funct` shows bits 5:0. With `ctl_alu_a_sel`=0 and `ctl_alu_b_sel`=3, the result register captures PC + (sign-extended bits 15:0 shifted left by 2).
- R4: With `ctl_alu_a_sel`=1 and `ctl_alu_b_sel`=2, the ALU forms A + sign-extended bits 15:0. In a store cycle B drives `mem_wdata` and `ctl_mem_wr` drives `mem_we`.
- R5: The memory data register captures `mem_rdata` on every edge. With `ctl_rf_wr`=1, `ctl_rf_src_sel`=1 and `ctl_rf_dst_sel`=0, it is written to the register named by bits 20:16.
- R6: `ctl_alu_op` selects 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than, 5 NOR (6 and 7 act as add). With `ctl_rf_dst_sel`=1 and `ctl_rf_src_sel`=0, the result register is written to the register named by bits 15:11.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: The PC is written when `ctl_pc_wr` is 1, or when `ctl_pc_wr_cond` is 1 and the ALU zero flag is 1. In any other cycle it holds. With `ctl_pc_src`=1 the new PC comes from the result register.
- R9: With `ctl_pc_src`=2 the new PC is PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R10: `alu_zero` is 1 exactly when the present ALU output is all zeros.
- R11: `ctl_addr_sel` puts the PC (0) or the result register (1) on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_ir_wr | input | 1 | Load instruction register |
| ctl_pc_wr | input | 1 | Unconditional PC write |
| ctl_pc_wr_cond | input | 1 | PC write when ALU zero flag is set |
| ctl_addr_sel | input | 1 | Memory address: 0 PC, 1 result register |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_rf_wr | input | 1 | Register file write enable |
| ctl_rf_dst_sel | input | 1 | Destination: 0 bits 20:16, 1 bits 15:11 |
| ctl_rf_src_sel | input | 1 | Write data: 0 result register, 1 memory data register |
| ctl_alu_a_sel | input | 1 | ALU A: 0 PC, 1 operand A |
| ctl_alu_b_sel | input | 2 | ALU B: 0 operand B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| ctl_alu_op | input | 3 | ALU operation code |
| ctl_pc_src | input | 2 | PC source: 0 ALU output, 1 result register, 2 jump target |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| ir_opcode | output | 6 | Instruction bits 31:26 |
| ir_funct | output | 6 | Instruction bits 5:0 |
| alu_zero | output | 1 | ALU output is zero |

## Verification
A corrupted PC shows on `mem_addr` at the very next fetch. A wrong branch or jump decision therefore surfaces within one instruction. A bad operand register, a wrong register file write or a faulty sign extension stays hidden until a later store carries the value out on `mem_wdata` or `mem_addr`, or until a compare drives `alu_zero`. So the bench stores every computed register and branches on the results. An instruction register that failed to hold would give a wrong `ir_opcode` or `ir_funct` in the following decode cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4,
    ALU_NOR = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_FOUR = 2'd1,
    BSRC_IMM  = 2'd2,
    BSRC_IMM4 = 2'd3
  } b_src_e;

  typedef enum logic [1:0] {
    PSRC_ALU  = 2'd0,
    PSRC_RES  = 2'd1,
    PSRC_JUMP = 2'd2,
    PSRC_RSVD = 2'd3
  } pc_src_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [W-1:0]             wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][W-1:0]    rdata
);
  // One bank per read port, each written identically, so every bank is
  // a simple one-write/one-read RAM with a registered read.
  for (genvar p = 0; p < NRD; p++) begin : g_bank
    logic [W-1:0]  bank [DEPTH];
    logic [W-1:0]  q;
    logic [AW-1:0] ra_q;

    always_ff @(posedge clk) begin
      if (we && (waddr != '0)) bank[waddr] <= wdata;
      q    <= bank[raddr[p]];
      ra_q <= raddr[p];
    end

    assign rdata[p] = (ra_q == '0) ? '0 : q;
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          REG_CNT  = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_ir_wr,
  input  logic        ctl_pc_wr,
  input  logic        ctl_pc_wr_cond,
  input  logic        ctl_addr_sel,
  input  logic        ctl_mem_wr,
  input  logic        ctl_rf_wr,
  input  logic        ctl_rf_dst_sel,
  input  logic        ctl_rf_src_sel,
  input  logic        ctl_alu_a_sel,
  input  logic [1:0]  ctl_alu_b_sel,
  input  logic [2:0]  ctl_alu_op,
  input  logic [1:0]  ctl_pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic [5:0]  ir_opcode,
  output logic [5:0]  ir_funct,
  output logic        alu_zero
);
  localparam int RA_W  = $clog2(REG_CNT);
  localparam int IMM_W = 16;
  localparam int JMP_W = 26;
  localparam int TOP_W = XLEN - JMP_W - 2;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, res_q;
  logic [XLEN-1:0] a_q, b_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  logic [XLEN-1:0] imm_sx, imm_sh, jmp_tgt, pc_next, rf_wdata;
  logic [RA_W-1:0] rf_waddr;
  logic [1:0][RA_W-1:0] rf_raddr;
  logic [1:0][XLEN-1:0] rf_rdata;
  logic            pc_en;

  // Immediate forms and jump target
  assign imm_sx  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = imm_sx << 2;
  assign jmp_tgt = {pc_q[XLEN-1 -: TOP_W], ir_q[JMP_W-1:0], 2'b00};

  // ALU operand selection
  assign alu_a = ctl_alu_a_sel ? a_q : pc_q;

  always_comb begin
    unique case (b_src_e'(ctl_alu_b_sel))
      BSRC_FOUR: alu_b = XLEN'(4);
      BSRC_IMM:  alu_b = imm_sx;
      BSRC_IMM4: alu_b = imm_sh;
      default:   alu_b = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) i_alu (
    .op   (alu_op_e'(ctl_alu_op)),
    .a    (alu_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // PC update
  assign pc_en = ctl_pc_wr | (ctl_pc_wr_cond & alu_zero);

  always_comb begin
    unique case (pc_src_e'(ctl_pc_src))
      PSRC_RES:  pc_next = res_q;
      PSRC_JUMP: pc_next = jmp_tgt;
      default:   pc_next = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mdr_q <= '0;
      res_q <= '0;
    end else begin
      if (pc_en)     pc_q <= pc_next;
      if (ctl_ir_wr) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      res_q <= alu_y;
    end
  end

  // Register file; its registered read outputs serve as A and B
  assign rf_raddr[0] = ir_q[21 +: RA_W];
  assign rf_raddr[1] = ir_q[16 +: RA_W];
  assign rf_waddr    = ctl_rf_dst_sel ? ir_q[11 +: RA_W] : ir_q[16 +: RA_W];
  assign rf_wdata    = ctl_rf_src_sel ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .DEPTH(REG_CNT), .NRD(2)) i_regfile (
    .clk   (clk),
    .we    (ctl_rf_wr),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign a_q = rf_rdata[0];
  assign b_q = rf_rdata[1];

  // Memory port and decode outputs
  assign mem_addr  = ctl_addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl_mem_wr;
  assign ir_opcode = ir_q[31:26];
  assign ir_funct  = ir_q[5:0];

  // R2: instruction register holds unless loaded
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_ir_wr |=> $stable(ir_q));

  // R2: load takes the memory word
  a_r2_ir_load: assert property (@(posedge clk) disable iff (rst)
    ctl_ir_wr |=> (ir_q == $past(mem_rdata)));

  // R8: no enable, no PC change
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> $stable(pc_q));

  // R9: jump keeps upper PC bits and lands word aligned
  a_r9_jump_tgt: assert property (@(posedge clk) disable iff (rst)
    (ctl_pc_wr && (ctl_pc_src == 2'd2)) |=>
      ((pc_q[1:0] == 2'b00) && (pc_q[31:28] == $past(pc_q[31:28]))));

  // R7: register 0 reads back as zero
  a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rf_raddr[0] == '0) |=> (a_q == '0));

  // R5: memory data register follows the memory every cycle
  a_r5_mdr_load: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mdr_q == $past(mem_rdata)));
endmodule

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_ir_wr, ctl_pc_wr, ctl_pc_wr_cond, ctl_addr_sel, ctl_mem_wr;
  logic        ctl_rf_wr, ctl_rf_dst_sel, ctl_rf_src_sel, ctl_alu_a_sel;
  logic [1:0]  ctl_alu_b_sel, ctl_pc_src;
  logic [2:0]  ctl_alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, alu_zero;
  logic [5:0]  ir_opcode, ir_funct;

  always #4 clk = ~clk;

  mc_datapath i_mc_datapath (.*);

  // Memory model
  logic [31:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  // Scoreboard
  typedef struct { int port; logic [31:0] exp; string req; } exp_t;
  exp_t sbq[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic [31:0] port_val(int p);
    case (p)
      0: return mem_addr;
      1: return mem_wdata;
      2: return {31'd0, mem_we};
      3: return {31'd0, alu_zero};
      4: return {26'd0, ir_opcode};
      default: return {26'd0, ir_funct};
    endcase
  endfunction

  task automatic expect_p(int p, logic [31:0] v, string r);
    exp_t e;
    e.port = p; e.exp = v; e.req = r;
    sbq.push_back(e);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sbq.pop_front();
      act = port_val(e.port);
      n_chk++;
      if (act !== e.exp) begin
        n_err++;
        $display("FAIL %s port%0d actual=%h expected=%h", e.req, e.port, act, e.exp);
      end
    end
  end

  // Reference model state
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  function automatic logic [31:0] sx(logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] ref_alu(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return {31'd0, $signed(a) < $signed(b)};
      3'd5: return ~(a | b);
      default: return a + b;
    endcase
  endfunction

  function automatic logic [5:0] funct_of(logic [2:0] op);
    case (op)
      3'd1: return 6'h22;
      3'd2: return 6'h24;
      3'd3: return 6'h25;
      3'd4: return 6'h2A;
      3'd5: return 6'h27;
      default: return 6'h20;
    endcase
  endfunction

  task automatic clear_ctl;
    ctl_ir_wr = 0; ctl_pc_wr = 0; ctl_pc_wr_cond = 0; ctl_addr_sel = 0;
    ctl_mem_wr = 0; ctl_rf_wr = 0; ctl_rf_dst_sel = 0; ctl_rf_src_sel = 0;
    ctl_alu_a_sel = 0; ctl_alu_b_sel = 0; ctl_alu_op = 0; ctl_pc_src = 0;
  endtask

  task automatic next_cycle;
    @(posedge clk); #1;
    clear_ctl();
  endtask

  task automatic fetch(logic [31:0] instr);
    next_cycle();
    mem[mpc[9:2]] = instr;
    ctl_ir_wr = 1; ctl_alu_a_sel = 0; ctl_alu_b_sel = 2'd1;
    ctl_alu_op = 3'd0; ctl_pc_wr = 1; ctl_pc_src = 2'd0;
    expect_p(0, mpc, "R2 R8 R11 pc at fetch");
    mpc = mpc + 4;
  endtask

  task automatic decode(logic [5:0] op);
    next_cycle();
    ctl_alu_a_sel = 0; ctl_alu_b_sel = 2'd3; ctl_alu_op = 3'd0;
    expect_p(4, {26'd0, op}, "R3 opcode");
  endtask

  task automatic do_lw(int rt, int rs, logic [15:0] imm);
    logic [31:0] addr;
    fetch({6'h23, 5'(rs), 5'(rt), imm});
    decode(6'h23);
    next_cycle();
    ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'd2; ctl_alu_op = 3'd0;
    next_cycle();
    addr = mreg[rs] + sx(imm);
    ctl_addr_sel = 1;
    expect_p(0, addr, "R4 R11 load address");
    next_cycle();
    ctl_rf_wr = 1; ctl_rf_dst_sel = 0; ctl_rf_src_sel = 1;
    if (rt != 0) mreg[rt] = mem[addr[9:2]];
  endtask

  task automatic do_sw(int rt, int rs, logic [15:0] imm, string r);
    fetch({6'h2B, 5'(rs), 5'(rt), imm});
    decode(6'h2B);
    next_cycle();
    ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'd2; ctl_alu_op = 3'd0;
    next_cycle();
    ctl_addr_sel = 1; ctl_mem_wr = 1;
    expect_p(0, mreg[rs] + sx(imm), "R4 store address");
    expect_p(1, mreg[rt], r);
    expect_p(2, 32'd1, "R4 write strobe");
  endtask

  task automatic do_r(logic [2:0] op, int rd, int rs, int rt);
    logic [31:0] res;
    fetch({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, funct_of(op)});
    decode(6'h00);
    expect_p(5, {26'd0, funct_of(op)}, "R3 funct");
    next_cycle();
    res = ref_alu(op, mreg[rs], mreg[rt]);
    ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'd0; ctl_alu_op = op;
    expect_p(3, {31'd0, res == 32'd0}, "R10 zero flag");
    next_cycle();
    ctl_rf_wr = 1; ctl_rf_dst_sel = 1; ctl_rf_src_sel = 0;
    if (rd != 0) mreg[rd] = res;
  endtask

  task automatic do_beq(int rs, int rt, logic [15:0] imm);
    logic [31:0] tgt;
    fetch({6'h04, 5'(rs), 5'(rt), imm});
    decode(6'h04);
    tgt = mpc + (sx(imm) << 2);
    next_cycle();
    ctl_alu_a_sel = 1; ctl_alu_b_sel = 2'd0; ctl_alu_op = 3'd1;
    ctl_pc_wr_cond = 1; ctl_pc_src = 2'd1;
    expect_p(3, {31'd0, mreg[rs] == mreg[rt]}, "R8 R10 branch compare");
    if (mreg[rs] == mreg[rt]) mpc = tgt;
  endtask

  task automatic do_j(logic [25:0] t);
    fetch({6'h02, t});
    decode(6'h02);
    next_cycle();
    ctl_pc_wr = 1; ctl_pc_src = 2'd2;
    mpc = {mpc[31:28], t, 2'b00};
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mem[192] = 32'h0000_0007;
    mem[193] = 32'hFFFF_FFF9;
    mem[194] = 32'h8000_0000;
    mem[195] = 32'h0000_0314;
    mpc = 32'd0;
    clear_ctl();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    expect_p(0, 32'd0, "R1 reset pc");
    expect_p(4, 32'd0, "R1 reset instruction");

    // Loads (R5) including a large-negative value
    do_lw(1, 0, 16'h0300);
    do_lw(2, 0, 16'h0304);
    do_lw(4, 0, 16'h0308);
    do_lw(11, 0, 16'h030C);

    // Every ALU operation (R6)
    do_r(3'd0, 3, 1, 2);
    do_r(3'd1, 5, 1, 2);
    do_r(3'd2, 6, 2, 1);
    do_r(3'd3, 7, 1, 2);
    do_r(3'd4, 8, 2, 1);
    do_r(3'd4, 9, 1, 4);
    do_r(3'd5, 10, 1, 2);
    for (int r = 3; r <= 10; r++) do_sw(r, 0, 16'(32'h0340 + 4 * r), "R6 result stored");

    // Negative displacement (R4), load of stored data (R5)
    do_sw(5, 11, 16'hFFFC, "R4 store data");
    do_lw(12, 11, 16'hFFFC);
    do_sw(12, 11, 16'h0000, "R5 loaded value");

    // Register 0 stays zero (R7)
    do_lw(0, 0, 16'h0300);
    do_r(3'd0, 0, 1, 1);
    do_sw(0, 0, 16'h0318, "R7 reg0 still zero");
    do_sw(1, 0, 16'h031C, "R3 operand B");

    // Branches (R8, R3 target) and jump (R9)
    do_beq(1, 1, 16'h0002);
    do_beq(1, 2, 16'h0005);
    do_beq(3, 0, 16'hFFF8);
    do_j(26'h40);
    do_r(3'd1, 13, 1, 1);
    do_j(26'h3FF_FF80);
    do_sw(7, 0, 16'h0320, "R9 after jump");

    next_cycle();
    expect_p(0, mpc, "R8 R9 final pc");
    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule